// File: doc/BRIEF.md
# Timed Three-State Dwell Controller

This block is a synchronous Moore controller with three states. IDLE waits for the input `x_in`. FIXED stays for a set number of clock cycles. LINGER stays for a minimum number of cycles and also waits for `x_in` to go low. A single cycle counter serves both timed states. It is held at zero in IDLE and cleared whenever the state changes. The two dwell lengths are elaboration-time parameters.

The state is shown on a 3-bit one-hot output decoded from the state register alone, so `x_in` reaches the output only through a clock edge. The transitions are:

- IDLE→FIXED: `x_in` is high at the edge.
- FIXED→LINGER: purely timed, when the counter reaches `FIXED_CYCLES-1`.
- LINGER→IDLE: conditional-timed, when the counter has reached `LINGER_CYCLES-1` and `x_in` is low.
- Self-loops: IDLE stays while `x_in` is low, FIXED stays until its count expires, and LINGER stays otherwise.

Top module: `dwell_fsm`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in IDLE with the counter at zero, so `state_oh` reads 3'b001 in the cycle after any reset edge.
- R2: In IDLE the controller moves to FIXED at the first rising edge that samples `x_in`=1, and stays in IDLE at every edge that samples `x_in`=0.
- R3: FIXED lasts exactly `FIXED_CYCLES` cycles (default 3), whatever `x_in` does, and is always followed by LINGER.
- R4: LINGER lasts at least `LINGER_CYCLES` cycles (default 2). It moves to IDLE at the first edge where the counter has reached `LINGER_CYCLES-1` and `x_in`=0, and stays in LINGER otherwise.
- R5: The counter is zero in IDLE and is cleared on every state change. In LINGER it saturates at `LINGER_CYCLES-1`, so every new visit to FIXED again lasts the full `FIXED_CYCLES`.
- R6: `state_oh` is 3'b001 in IDLE, 3'b010 in FIXED and 3'b100 in LINGER. It depends only on the registered state and never changes between clock edges when `x_in` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 1 | Control input sampled at each edge |
| state_oh | output | 3 | One-hot registered state code |

## Verification
The embedded assertions check every cycle that:
- the output stays one-hot;
- the counter is zero in IDLE and right after any state change;
- FIXED advances its counter by one until it expires;
- LINGER holds while `x_in` is high, with the counter saturated.

Only the bench scenarios can show the full dwell lengths seen at the output:
- FIXED lasting exactly three cycles after a long IDLE period or a stretched LINGER;
- LINGER leaving after exactly two cycles when `x_in` is already low;
- reset taking effect in the middle of FIXED;
- the output staying unchanged when `x_in` is pulsed between clock edges.

// File: rtl/dwell_fsm_pkg.sv
package dwell_fsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIXED  = 2'd1,
        ST_LINGER = 2'd2
    } dwell_state_t;

    localparam logic [2:0] OH_IDLE   = 3'b001;
    localparam logic [2:0] OH_FIXED  = 3'b010;
    localparam logic [2:0] OH_LINGER = 3'b100;

endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [WIDTH-1:0] last,
    output logic [WIDTH-1:0] cnt,
    output logic             at_last
);

    assign at_last = (cnt == last);

    // Counts up, clears on request, saturates at the threshold
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!at_last) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TIMER_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (!clr && at_last) |=> (cnt == $past(cnt)))  // R5
        else $error("timer moved past threshold");

endmodule

// File: rtl/dwell_next.sv
module dwell_next
    import dwell_fsm_pkg::*;
(
    input  dwell_state_t cur,
    input  logic         x_in,
    input  logic         at_last,
    output dwell_state_t nxt
);

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_IDLE:   if (x_in)             nxt = ST_FIXED;
            ST_FIXED:  if (at_last)          nxt = ST_LINGER;
            ST_LINGER: if (at_last && !x_in) nxt = ST_IDLE;
            default:                         nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/dwell_fsm.sv
module dwell_fsm
    import dwell_fsm_pkg::*;
#(
    parameter int FIXED_CYCLES  = 3,
    parameter int LINGER_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       x_in,
    output logic [2:0] state_oh
);

    localparam int MAX_DWELL = (FIXED_CYCLES > LINGER_CYCLES) ? FIXED_CYCLES : LINGER_CYCLES;
    localparam int TW        = (MAX_DWELL > 1) ? $clog2(MAX_DWELL) : 1;
    localparam logic [TW-1:0] FIXED_LAST  = TW'(FIXED_CYCLES - 1);
    localparam logic [TW-1:0] LINGER_LAST = TW'(LINGER_CYCLES - 1);

    dwell_state_t    state_q;
    dwell_state_t    state_d;
    logic [TW-1:0]   tmr_cnt;
    logic [TW-1:0]   tmr_last;
    logic            tmr_at_last;
    logic            tmr_clr;

    // Threshold selection per timed state
    always_comb begin
        tmr_last = '0;
        unique case (state_q)
            ST_FIXED:  tmr_last = FIXED_LAST;
            ST_LINGER: tmr_last = LINGER_LAST;
            default:   tmr_last = '0;
        endcase
    end

    // Counter is held in IDLE and cleared on every transition
    assign tmr_clr = (state_q == ST_IDLE) || (state_d != state_q);

    dwell_timer #(.WIDTH(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .last    (tmr_last),
        .cnt     (tmr_cnt),
        .at_last (tmr_at_last)
    );

    dwell_next u_next (
        .cur     (state_q),
        .x_in    (x_in),
        .at_last (tmr_at_last),
        .nxt     (state_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore output decode
    always_comb begin
        state_oh = OH_IDLE;
        unique case (state_q)
            ST_IDLE:   state_oh = OH_IDLE;
            ST_FIXED:  state_oh = OH_FIXED;
            ST_LINGER: state_oh = OH_LINGER;
            default:   state_oh = OH_IDLE;
        endcase
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (state_oh == OH_IDLE))  // R1
        else $error("reset did not return to IDLE");

    AST_IDLE_GO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && x_in) |=> (state_q == ST_FIXED))  // R2
        else $error("IDLE ignored x_in");

    AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !x_in) |=> (state_q == ST_IDLE))  // R2
        else $error("IDLE left without x_in");

    AST_FIXED_COUNT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIXED && tmr_cnt != FIXED_LAST)
            |=> (state_q == ST_FIXED && tmr_cnt == $past(tmr_cnt) + 1'b1))  // R3
        else $error("FIXED dwell broken");

    AST_FIXED_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIXED && tmr_cnt == FIXED_LAST) |=> (state_q == ST_LINGER))  // R3
        else $error("FIXED did not end on time");

    AST_LINGER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LINGER && x_in) |=> (state_q == ST_LINGER))  // R4
        else $error("LINGER left while x_in high");

    AST_LINGER_MIN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LINGER && tmr_cnt != LINGER_LAST) |=> (state_q == ST_LINGER))  // R4
        else $error("LINGER shorter than minimum");

    AST_IDLE_TIMER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (tmr_cnt == '0))  // R5
        else $error("timer running in IDLE");

    AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state_q != $past(state_q)) |-> (tmr_cnt == '0))  // R5
        else $error("timer not cleared on transition");

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1)  // R6
        else $error("output not one-hot");

endmodule

// File: tb/dwell_fsm_test.sv
module dwell_fsm_test;

    localparam int FB = 3;
    localparam int LC = 2;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       x_in = 1'b0;
    logic [2:0] state_oh;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    exp_t q[$];
    int   m_st  = 0;
    int   m_cnt = 0;

    always #5 clk = ~clk;

    dwell_fsm #(.FIXED_CYCLES(FB), .LINGER_CYCLES(LC)) uut (
        .clk      (clk),
        .rst      (rst),
        .x_in     (x_in),
        .state_oh (state_oh)
    );

    function automatic logic [2:0] code_of(int st);
        case (st)
            0: return 3'b001;
            1: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    task automatic check(logic [2:0] act, logic [2:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: state_oh=%b expected %b", tag, act, exp);
        end
    endtask

    // Driver: one clock cycle of stimulus, pushes the expected outcome
    task automatic step(logic xv, bit rv, bit glitch, string tag);
        int nst;
        int lim;
        exp_t e;
        @(negedge clk);
        if (glitch) begin
            x_in = ~xv;
            #2;
            check(state_oh, code_of(m_st), "R6");
            x_in = xv;
            #1;
            check(state_oh, code_of(m_st), "R6");
        end
        x_in = xv;
        rst  = rv;
        if (rv) begin
            nst   = 0;
            m_cnt = 0;
        end else begin
            lim = (m_st == 1) ? FB : LC;
            case (m_st)
                0: nst = xv ? 1 : 0;
                1: nst = (m_cnt == FB - 1) ? 2 : 1;
                default: nst = (m_cnt == LC - 1 && !xv) ? 0 : 2;
            endcase
            if (nst != m_st || nst == 0) m_cnt = 0;
            else if (m_cnt < lim - 1) m_cnt = m_cnt + 1;
        end
        m_st  = nst;
        e.exp = code_of(nst);
        e.tag = tag;
        q.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(state_oh, e.exp, e.tag);
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(1'b1, 1'b1, 1'b0, "R1");
        // R2: IDLE waits while x_in low; R6 pulse between edges
        step(1'b0, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, "R2");
        // R2: go to FIXED on first x_in high
        step(1'b1, 1'b0, 1'b0, "R2");
        // R3: FIXED exactly three cycles regardless of x_in
        step(1'b0, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b0, 1'b0, "R3");
        step(1'b0, 1'b0, 1'b0, "R3");
        // R4: LINGER stretched while x_in high (timer saturates, R5)
        step(1'b1, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b0, 1'b1, "R4");
        step(1'b1, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R4");
        // R5: re-entry to FIXED lasts the full length
        step(1'b1, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R5");
        // R4: LINGER lasts exactly the minimum when x_in already low
        step(1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, "R2");
        // R1: reset in the middle of FIXED
        step(1'b1, 1'b0, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, "R3");
        step(1'b1, 1'b1, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, "R2");
        // R5: full FIXED after reset-aborted visit
        step(1'b0, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, "R6");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule